// File: doc/BRIEF.md
# Nested Core Event Controller

This block sits between a processor core and sixteen event sources. It captures each incoming event request in a latch register. A per-event enable mask then decides which latched events may be serviced. A pending register records every event the core has accepted and not yet returned from, so it reflects the current nesting depth. From these three registers the controller raises a single service request. That request names the highest-priority latched, enabled event, and only if that event outranks everything the core is already handling.

The core answers a service request with an acknowledge. In that cycle the event moves from the latch register to the pending register. When the core finishes a handler it pulses a return strobe, and the innermost (highest-priority) pending event is retired. Software uses a small register port to inspect and modify the registers. A supervisor-mode qualifier guards the mask and pending registers. Events at or above a configurable index count as general-purpose. They also need a global enable, which two dedicated command strobes turn on and off.

Top module: `nce_core`

## Requirements
- R1: After reset the latch, mask and pending registers are all zero, the global enable is off and `svc_req` is low.
- R2: An event request bit high in a cycle sets the matching latch bit at the next clock edge, whatever the mask holds.
- R3: A latch-register write (`reg_sel` = 0) loads `reg_wdata` only into bits whose mask bit is 0. Latch bits whose mask bit is 1 keep their value. The write is allowed in any mode.
- R4: A mask-register write (`reg_sel` = 1) takes effect at the next edge only when `sup_mode` is high. Without `sup_mode` the mask is left unchanged.
- R5: `reg_rdata` is combinational and shows the latch register for `reg_sel` = 0, the mask for 1 and the pending register for 2. It reads zero for 3. The mask and pending registers read as zero while `sup_mode` is low.
- R6: An event whose index is `GP_FIRST` (default 7) or above is eligible only while the global enable is on. Lower-index events ignore the global enable.
- R7: An event is eligible when it is latched and unmasked (plus R6). `svc_req` is high exactly when some eligible event has an index below the lowest set pending bit, or when the pending register is empty. `svc_id` then gives the lowest such index.
- R8: `svc_ack` while `svc_req` is high clears latch bit `svc_id` and sets pending bit `svc_id` at the next edge. `svc_ack` while `svc_req` is low has no effect.
- R9: `evt_ret` clears the lowest-index set pending bit at the next edge. With the pending register empty it changes nothing.
- R10: `gen_en_set` turns the global enable on and `gen_en_clr` turns it off, both from the next edge. When both are high, clear wins.
- R11: An event request in the same cycle as an acknowledge or latch write for that bit leaves the latch bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_req | input | 16 | Event request lines, bit i = event i |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 latch, 1 mask, 2 pending, 3 none |
| reg_wdata | input | 16 | Write data |
| sup_mode | input | 1 | Supervisor-mode qualifier for the access |
| reg_rdata | output | 16 | Read data of the selected register |
| gen_en_set | input | 1 | Global general-purpose enable on |
| gen_en_clr | input | 1 | Global general-purpose enable off |
| svc_req | output | 1 | Service request to the core |
| svc_id | output | 4 | Index of the requested event |
| svc_ack | input | 1 | Core accepts the requested event |
| evt_ret | input | 1 | Core returns from the innermost event |

## Verification
Embedded properties check on every cycle the local rules. A service request always points at a latched, unmasked event that no pending event outranks. A general-purpose event is never requested while the global enable is off. An accepted event leaves the latch and enters the pending register. A return on an empty pending register changes nothing, and the pending count grows by at most one per cycle. A mask write outside supervisor mode is dropped. Masked latch bits survive writes, and clear beats set on the global enable. Other behaviours appear only across a scenario, and the bench shows them with a reference model over random and directed traffic. These include the full nesting order over several acknowledges and returns, the read-back masking in user mode, and the exact latch contents after writes that collide with new requests.

// File: rtl/nce_pkg.sv
package nce_pkg;
  localparam int unsigned NCE_EVENTS = 16;

  typedef enum logic [1:0] {
    SEL_LATCH = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_PEND  = 2'd2,
    SEL_NONE  = 2'd3
  } nce_sel_e;
endpackage

// File: rtl/nce_prio_pick.sv
module nce_prio_pick #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  // lowest set index wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
    onehot = hit ? (N'(1) << idx) : '0;
  end

  always_comb begin
    AST_PICK_ONEHOT: assert ($onehot0(onehot) && (hit == (onehot != '0))); // R7
  end
endmodule

// File: rtl/nce_latch_bank.sv
module nce_latch_bank #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_req,
  input  logic         wr_en,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] mask,
  input  logic         ack_hit,
  input  logic [N-1:0] ack_onehot,
  output logic [N-1:0] lat
);
  logic [N-1:0] lat_wr;
  logic [N-1:0] lat_nxt;
  logic         lat_en;

  always_comb begin
    lat_wr  = wr_en ? ((lat & mask) | (wdata & ~mask)) : lat;
    lat_nxt = (lat_wr & ~(ack_hit ? ack_onehot : '0)) | ev_req;
    lat_en  = wr_en | ack_hit | (ev_req != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat <= '0;
    end else if (lat_en) begin
      lat <= lat_nxt;
    end
  end

  AST_EVENT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ev_req) & ~lat) == '0)); // R2
  AST_ACK_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && ((ev_req & ack_onehot) == '0)) |=> ((lat & $past(ack_onehot)) == '0)); // R8
  AST_MASKED_LATCH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ack_hit && ev_req == '0) |=> (((lat ^ $past(lat)) & $past(mask)) == '0)); // R3
endmodule

// File: rtl/nce_pend_track.sv
module nce_pend_track #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_hit,
  input  logic [N-1:0]  ack_onehot,
  input  logic          ret,
  output logic [N-1:0]  pend,
  output logic          top_hit,
  output logic [IW-1:0] top_idx
);
  logic [N-1:0] top_onehot;
  logic [N-1:0] pend_nxt;
  logic         pend_en;

  nce_prio_pick #(.N(N), .IW(IW)) top_pick_i (
    .vec    (pend),
    .hit    (top_hit),
    .idx    (top_idx),
    .onehot (top_onehot)
  );

  always_comb begin
    pend_nxt = (pend & ~(ret ? top_onehot : '0)) | (ack_hit ? ack_onehot : '0);
    pend_en  = ret | ack_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (pend_en) begin
      pend <= pend_nxt;
    end
  end

  AST_PEND_GROWS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(pend) <= $countones($past(pend)) + 1)); // R8
  AST_RET_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !ack_hit && pend == '0) |=> (pend == '0)); // R9
  AST_ACK_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> ((pend & $past(ack_onehot)) != '0)); // R8
endmodule

// File: rtl/nce_ctrl_regs.sv
module nce_ctrl_regs
  import nce_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  nce_sel_e     sel,
  input  logic [N-1:0] wdata,
  input  logic         sup_mode,
  input  logic         gen_set,
  input  logic         gen_clr,
  input  logic [N-1:0] lat,
  input  logic [N-1:0] pend,
  output logic [N-1:0] mask,
  output logic         gen_en,
  output logic [N-1:0] rdata
);
  logic         mask_en;
  logic         gen_nxt;
  logic         gen_upd;

  always_comb begin
    mask_en = reg_wr && sup_mode && (sel == SEL_MASK);
    gen_upd = gen_set | gen_clr;
    gen_nxt = gen_clr ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
    end else if (mask_en) begin
      mask <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en <= 1'b0;
    end else if (gen_upd) begin
      gen_en <= gen_nxt;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_LATCH: rdata = lat;
      SEL_MASK:  rdata = sup_mode ? mask : '0;
      SEL_PEND:  rdata = sup_mode ? pend : '0;
      default:   rdata = '0;
    endcase
  end

  AST_MASK_SUP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !sup_mode && sel == SEL_MASK) |=> $stable(mask)); // R4
  AST_GEN_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    gen_clr |=> !gen_en); // R10
  AST_GEN_SET_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_set && !gen_clr) |=> gen_en); // R10
endmodule

// File: rtl/nce_core.sv
module nce_core
  import nce_pkg::*;
#(
  parameter int unsigned N        = NCE_EVENTS,
  parameter int unsigned GP_FIRST = 7,
  localparam int unsigned IW      = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  ev_req,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [N-1:0]  reg_wdata,
  input  logic          sup_mode,
  output logic [N-1:0]  reg_rdata,
  input  logic          gen_en_set,
  input  logic          gen_en_clr,
  output logic          svc_req,
  output logic [IW-1:0] svc_id,
  input  logic          svc_ack,
  input  logic          evt_ret
);
  logic [1:0]    rst_sync;
  logic          rst_sync_n;
  nce_sel_e      sel;
  logic [N-1:0]  lat;
  logic [N-1:0]  mask;
  logic [N-1:0]  pend;
  logic          gen_en;
  logic          top_hit;
  logic [IW-1:0] top_idx;
  logic [N-1:0]  gp_ok;
  logic [N-1:0]  above_top;
  logic [N-1:0]  cand;
  logic [N-1:0]  svc_onehot;
  logic          ack_hit;
  logic          lat_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync[1];

  always_comb begin
    sel     = nce_sel_e'(reg_sel);
    lat_wr  = reg_wr && (sel == SEL_LATCH);
    ack_hit = svc_ack && svc_req;
  end

  for (genvar g = 0; g < N; g++) begin : g_elig
    if (g >= GP_FIRST) begin : g_gp
      assign gp_ok[g] = gen_en;
    end else begin : g_core
      assign gp_ok[g] = 1'b1;
    end
    assign above_top[g] = !top_hit || (IW'(g) < top_idx);
  end

  assign cand = lat & mask & gp_ok & above_top;

  nce_prio_pick #(.N(N), .IW(IW)) svc_pick_i (
    .vec    (cand),
    .hit    (svc_req),
    .idx    (svc_id),
    .onehot (svc_onehot)
  );

  nce_latch_bank #(.N(N)) latch_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ev_req     (ev_req),
    .wr_en      (lat_wr),
    .wdata      (reg_wdata),
    .mask       (mask),
    .ack_hit    (ack_hit),
    .ack_onehot (svc_onehot),
    .lat        (lat)
  );

  nce_pend_track #(.N(N), .IW(IW)) pend_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ack_hit    (ack_hit),
    .ack_onehot (svc_onehot),
    .ret        (evt_ret),
    .pend       (pend),
    .top_hit    (top_hit),
    .top_idx    (top_idx)
  );

  nce_ctrl_regs #(.N(N)) regs_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .reg_wr   (reg_wr),
    .sel      (sel),
    .wdata    (reg_wdata),
    .sup_mode (sup_mode),
    .gen_set  (gen_en_set),
    .gen_clr  (gen_en_clr),
    .lat      (lat),
    .pend     (pend),
    .mask     (mask),
    .gen_en   (gen_en),
    .rdata    (reg_rdata)
  );

  AST_SVC_LATCHED_UNMASKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    svc_req |-> ((lat & mask & svc_onehot) != '0)); // R7
  AST_SVC_OUTRANKS_PEND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    svc_req |-> ((pend & (svc_onehot | (svc_onehot - N'(1)))) == '0)); // R7
  AST_GP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (svc_req && !gen_en) |-> (int'(svc_id) < int'(GP_FIRST))); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> (!svc_req && pend == '0 && lat == '0)); // R1
endmodule

// File: tb/nce_core_tb_top.sv
module nce_core_tb_top;
  localparam int N  = 16;
  localparam int GP = 7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ev_req;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [15:0] reg_wdata;
  logic        sup_mode;
  logic [15:0] reg_rdata;
  logic        gen_en_set;
  logic        gen_en_clr;
  logic        svc_req;
  logic [3:0]  svc_id;
  logic        svc_ack;
  logic        evt_ret;

  int checks   = 0;
  int failures = 0;

  logic [15:0] m_lat, m_mask, m_pend;
  logic        m_gen;

  always #5 clk = ~clk;

  nce_core dut_i (
    .clk(clk), .rst_n(rst_n), .ev_req(ev_req), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .sup_mode(sup_mode),
    .reg_rdata(reg_rdata), .gen_en_set(gen_en_set), .gen_en_clr(gen_en_clr),
    .svc_req(svc_req), .svc_id(svc_id), .svc_ack(svc_ack), .evt_ret(evt_ret)
  );

  function automatic int lowest(input logic [15:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int exp_svc();
    int top = lowest(m_pend);
    for (int i = 0; i < N; i++) begin
      if (m_lat[i] && m_mask[i] && (i < GP || m_gen) && (top < 0 || i < top))
        return i;
    end
    return -1;
  endfunction

  function automatic logic [15:0] exp_rd(input logic [1:0] s, input logic sup);
    case (s)
      2'd0: return m_lat;
      2'd1: return sup ? m_mask : 16'h0;
      2'd2: return sup ? m_pend : 16'h0;
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string rq, input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", rq, tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [15:0] ev, input logic wr, input logic [1:0] sel,
                      input logic [15:0] wd, input logic sup, input logic gs,
                      input logic gc, input logic ack, input logic ret, input string tag);
    int es;
    logic [15:0] lw;
    int top;
    @(negedge clk);
    ev_req = ev; reg_wr = wr; reg_sel = sel; reg_wdata = wd; sup_mode = sup;
    gen_en_set = gs; gen_en_clr = gc; svc_ack = ack; evt_ret = ret;
    #1;
    es = exp_svc();
    check("R7", tag, int'(svc_req), int'(es >= 0));
    if (es >= 0) check("R7", tag, int'(svc_id), es);
    check("R5", tag, int'(reg_rdata), int'(exp_rd(sel, sup)));
    // model update for the coming edge
    top = lowest(m_pend);
    lw  = (wr && sel == 2'd0) ? ((m_lat & m_mask) | (wd & ~m_mask)) : m_lat;
    if (ack && es >= 0) lw[es] = 1'b0;
    m_lat = lw | ev;
    if (ret && top >= 0) m_pend[top] = 1'b0;
    if (ack && es >= 0) m_pend[es] = 1'b1;
    if (wr && sel == 2'd1 && sup) m_mask = wd;
    if (gc) m_gen = 1'b0;
    else if (gs) m_gen = 1'b1;
  endtask

  task automatic idle(input logic [1:0] sel, input string tag);
    step(16'h0, 1'b0, sel, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    rst_n = 1'b0; ev_req = '0; reg_wr = 0; reg_sel = 0; reg_wdata = '0;
    sup_mode = 0; gen_en_set = 0; gen_en_clr = 0; svc_ack = 0; evt_ret = 0;
    m_lat = '0; m_mask = '0; m_pend = '0; m_gen = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state visible on every register and the request
    for (int s = 0; s < 4; s++) idle(2'(s), "R1");

    // R4: user-mode mask write dropped, supervisor write lands
    step(16'h0, 1, 2'd1, 16'hFFFF, 1'b0, 0, 0, 0, 0, "R4");
    idle(2'd1, "R4");
    step(16'h0, 0, 2'd1, 16'h0, 1'b0, 0, 0, 0, 0, "R5");
    step(16'h0, 1, 2'd1, 16'h00F0, 1'b1, 0, 0, 0, 0, "R4");
    idle(2'd1, "R4");

    // R2: events latch even when masked
    step(16'h0101, 0, 2'd0, 16'h0, 1'b1, 0, 0, 0, 0, "R2");
    idle(2'd0, "R2");

    // R3: latch write only reaches masked-off bits
    step(16'h0, 1, 2'd0, 16'hFFFF, 1'b0, 0, 0, 0, 0, "R3");
    idle(2'd0, "R3");
    step(16'h0, 1, 2'd0, 16'h0000, 1'b1, 0, 0, 0, 0, "R3");
    idle(2'd0, "R3");

    // R11: new request beats a clearing write
    step(16'h0008, 1, 2'd0, 16'h0000, 1'b1, 0, 0, 0, 0, "R11");
    idle(2'd0, "R11");

    // R6 / R10 / R8 / R9: nesting scenario
    step(16'h0, 1, 2'd1, 16'h0000, 1, 0, 0, 0, 0, "R3");
    step(16'h0, 1, 2'd0, 16'h0000, 1, 0, 0, 0, 0, "R3");
    step(16'h0, 1, 2'd1, 16'hFFFF, 1, 0, 0, 0, 0, "R4");
    step(16'h8000, 0, 2'd0, 16'h0, 1, 0, 0, 0, 0, "R6");
    step(16'h0, 0, 2'd0, 16'h0, 1, 1, 1, 0, 0, "R10");
    idle(2'd0, "R6");
    step(16'h0, 0, 2'd0, 16'h0, 1, 1, 0, 0, 0, "R10");
    idle(2'd2, "R6");
    step(16'h0, 0, 2'd2, 16'h0, 1, 0, 0, 1, 0, "R8");
    step(16'h0004, 0, 2'd2, 16'h0, 1, 0, 0, 0, 0, "R7");
    step(16'h0, 0, 2'd2, 16'h0, 1, 0, 0, 1, 0, "R8");
    step(16'h0010, 0, 2'd2, 16'h0, 1, 0, 0, 1, 0, "R8");
    idle(2'd2, "R7");
    step(16'h0, 0, 2'd2, 16'h0, 1, 0, 0, 0, 1, "R9");
    step(16'h0010, 0, 2'd0, 16'h0, 1, 0, 0, 1, 1, "R11");
    idle(2'd0, "R11");
    step(16'h0, 0, 2'd2, 16'h0, 1, 0, 0, 0, 1, "R9");
    step(16'h0, 0, 2'd2, 16'h0, 1, 0, 0, 0, 1, "R9");
    step(16'h0, 0, 2'd2, 16'h0, 1, 0, 1, 0, 1, "R9");
    idle(2'd2, "R9");

    // random traffic against the model
    for (int k = 0; k < 4000; k++) begin
      logic [15:0] ev;
      ev = (($urandom % 6) == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
      step(ev, ($urandom % 6) == 0, 2'($urandom % 4), 16'($urandom),
           ($urandom % 4) != 0, ($urandom % 12) == 0, ($urandom % 40) == 0,
           ($urandom % 3) == 0, ($urandom % 5) == 0, "RND");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule